// File: doc/BRIEF.md
# Banked CPU Register File

This block is the general-purpose register file of a small 16-bit processor core. It keeps two identical banks of working registers: four data registers, two address registers and a frame base. A bit in the flag register decides which bank every banked access refers to. Data registers 0 and 1 can be reached as separate low and high bytes. Data registers 2 and 3 extend registers 0 and 1 into 32-bit pairs, and address register 1 extends address register 0 the same way. The file also holds the state that both banks share: an internal and a user stack pointer, where a second flag bit picks the one the stack alias reaches, a 20-bit program counter, a 20-bit interrupt vector base split into high and low parts, a static base register and the flag register.

The core drives a single synchronous write port. A 4-bit register code and a 2-bit width code pick the target, and two combinational read ports use the same codes. Width codes are 0 for the low byte, 1 for the high byte, 2 for a word and 3 for a doubleword. A code that does not suit the chosen register is rejected: the write does nothing and the read returns zero. The asynchronous active-low reset is released synchronously inside the block, so the registers come out of reset two clock edges after the reset input rises.

Top module: `banked_regfile`

## Requirements
- R1: While reset is active and after it is released, every register reads zero. Bank 0 and the internal stack pointer are therefore selected.
- R2: Flag bit 4 picks the active bank. Register codes 0 to 3 (data 0 to 3), 4 and 5 (address 0 and 1) and 6 (frame base) reach only the active bank. A write never changes the other bank.
- R3: On codes 0 and 1, width 0 reaches bits 7:0 and width 1 reaches bits 15:8. A byte write leaves the other byte unchanged, and a byte read returns the byte zero-extended.
- R4: A doubleword on code 0 is {data 2, data 0}, on code 1 is {data 3, data 1} and on code 4 is {address 1, address 0}. A doubleword write updates both halves on the same clock edge.
- R5: Code 7 with width 2 reaches the internal stack pointer when flag bit 5 is 0 and the user stack pointer when it is 1. Codes 8 (internal) and 9 (user) reach each stack pointer directly.
- R6: A write to the flags (code 14, width 2) changes the bank and stack selection only from the next cycle on. Reads in the cycle of the write still use the old selection.
- R7: The program counter (code 10) accepts only width 3. A write keeps bits 19:0, and a read returns bits 31:20 as zero.
- R8: Code 11 with width 2 reaches vector base bits 19:16 through data bits 3:0. Code 12 with width 2 reaches bits 15:0, and code 12 with width 3 reaches all 20 bits. Unused read bits return zero.
- R9: The static base (code 13, width 2) and the flags (code 14, width 2) are shared by both banks and hold any 16-bit value.
- R10: A byte width on any code other than 0 and 1, width 2 on code 10, width 3 on any code other than 0, 1, 4, 10 and 12, and any access to code 15 is rejected. Such a write changes nothing and such a read returns zero.
- R11: The two read ports are independent, and each returns the register state as it was before the current cycle's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Register code of the write |
| wr_wid | input | 2 | Width code of the write |
| wr_data | input | 32 | Write data, right-aligned |
| rda_sel | input | 4 | Register code of read port A |
| rda_wid | input | 2 | Width code of read port A |
| rda_data | output | 32 | Read port A data, zero-extended |
| rdb_sel | input | 4 | Register code of read port B |
| rdb_wid | input | 2 | Width code of read port B |
| rdb_data | output | 32 | Read port B data, zero-extended |

## Verification
A flag write that flips the bank or the stack selection can fall in the same cycle as a read of a banked register or of the stack alias. The bench provokes this both on purpose and through random traffic that often hits the flag code. It judges the read in the write cycle against the old selection and the read one cycle later against the new one. A reference model in the bench keeps both banks and all shared registers and predicts every read of both ports before each clock edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DW    = 16;
  localparam int PCW   = 20;
  localparam int NBANK = 2;
  localparam int NBREG = 7;

  localparam logic [1:0] WID_BLO   = 2'd0;
  localparam logic [1:0] WID_BHI   = 2'd1;
  localparam logic [1:0] WID_WORD  = 2'd2;
  localparam logic [1:0] WID_DWORD = 2'd3;

  localparam logic [3:0] SEL_D0   = 4'd0;
  localparam logic [3:0] SEL_D1   = 4'd1;
  localparam logic [3:0] SEL_D2   = 4'd2;
  localparam logic [3:0] SEL_D3   = 4'd3;
  localparam logic [3:0] SEL_X0   = 4'd4;
  localparam logic [3:0] SEL_X1   = 4'd5;
  localparam logic [3:0] SEL_FRM  = 4'd6;
  localparam logic [3:0] SEL_SP   = 4'd7;
  localparam logic [3:0] SEL_ISP  = 4'd8;
  localparam logic [3:0] SEL_USP  = 4'd9;
  localparam logic [3:0] SEL_PC   = 4'd10;
  localparam logic [3:0] SEL_VBH  = 4'd11;
  localparam logic [3:0] SEL_VBL  = 4'd12;
  localparam logic [3:0] SEL_SB   = 4'd13;
  localparam logic [3:0] SEL_FLG  = 4'd14;
  localparam logic [3:0] SEL_NONE = 4'd15;

  localparam int FLG_BANK_BIT = 4;
  localparam int FLG_USTK_BIT = 5;

  function automatic logic rf_is_banked(input logic [3:0] sel);
    return sel <= SEL_FRM;
  endfunction

  function automatic logic rf_legal(input logic [3:0] sel, input logic [1:0] wid);
    logic ok;
    case (wid)
      WID_BLO, WID_BHI: ok = (sel == SEL_D0) || (sel == SEL_D1);
      WID_WORD:         ok = (sel != SEL_PC) && (sel != SEL_NONE);
      default:          ok = (sel == SEL_D0) || (sel == SEL_D1) || (sel == SEL_X0) ||
                             (sel == SEL_PC) || (sel == SEL_VBL);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int W    = DW,
  parameter int NREG = NBREG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [3:0]              sel,
  input  logic [1:0]              wid,
  input  logic [2*W-1:0]          wdata,
  output logic [NREG-1:0][W-1:0]  q
);
  localparam int HB = W / 2;

  logic [NREG-1:0][W-1:0] q_nxt;
  int                     idx;

  assign idx = int'(sel[2:0]);

  always_comb begin
    q_nxt = q;
    case (wid)
      WID_BLO: if (sel == SEL_D0 || sel == SEL_D1) q_nxt[idx][HB-1:0] = wdata[HB-1:0];
      WID_BHI: if (sel == SEL_D0 || sel == SEL_D1) q_nxt[idx][W-1:HB] = wdata[HB-1:0];
      WID_WORD: if (idx < NREG) q_nxt[idx] = wdata[W-1:0];
      default: begin
        if (sel == SEL_D0 || sel == SEL_D1) begin
          q_nxt[idx]     = wdata[W-1:0];
          q_nxt[idx + 2] = wdata[2*W-1:W];
        end else if (sel == SEL_X0) begin
          q_nxt[SEL_X0] = wdata[W-1:0];
          q_nxt[SEL_X1] = wdata[2*W-1:W];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_nxt;
  end

  // R3: a low-byte write keeps the high byte of the same register
  a_r3_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wid == WID_BLO && sel == SEL_D0) |=> (q[0][W-1:HB] == $past(q[0][W-1:HB])));

  // R4: a pair write lands both halves on one edge
  a_r4_pair_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wid == WID_DWORD && sel == SEL_X0) |=>
      ({q[SEL_X1], q[SEL_X0]} == $past(wdata)));
endmodule

// File: rtl/rf_sysregs.sv
module rf_sysregs
  import rf_pkg::*;
#(
  parameter int W  = DW,
  parameter int AW = PCW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [3:0]     sel,
  input  logic [1:0]     wid,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   isp,
  output logic [W-1:0]   usp,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  vb,
  output logic [W-1:0]   sb,
  output logic [W-1:0]   flg
);
  logic [W-1:0]  isp_n, usp_n, sb_n, flg_n;
  logic [AW-1:0] pc_n, vb_n;
  logic          is_word;

  assign is_word = (wid == WID_WORD);

  always_comb begin
    isp_n = isp;
    usp_n = usp;
    pc_n  = pc;
    vb_n  = vb;
    sb_n  = sb;
    flg_n = flg;
    case (sel)
      SEL_SP:  if (is_word) begin
                 if (flg[FLG_USTK_BIT]) usp_n = wdata[W-1:0];
                 else                   isp_n = wdata[W-1:0];
               end
      SEL_ISP: if (is_word) isp_n = wdata[W-1:0];
      SEL_USP: if (is_word) usp_n = wdata[W-1:0];
      SEL_PC:  if (wid == WID_DWORD) pc_n = wdata[AW-1:0];
      SEL_VBH: if (is_word) vb_n[AW-1:W] = wdata[AW-W-1:0];
      SEL_VBL: begin
                 if (is_word)               vb_n[W-1:0] = wdata[W-1:0];
                 else if (wid == WID_DWORD) vb_n        = wdata[AW-1:0];
               end
      SEL_SB:  if (is_word) sb_n  = wdata[W-1:0];
      SEL_FLG: if (is_word) flg_n = wdata[W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isp <= '0;
      usp <= '0;
      pc  <= '0;
      vb  <= '0;
      sb  <= '0;
      flg <= '0;
    end else if (we) begin
      isp <= isp_n;
      usp <= usp_n;
      pc  <= pc_n;
      vb  <= vb_n;
      sb  <= sb_n;
      flg <= flg_n;
    end
  end

  // R5: with the internal pointer selected, the alias never touches the user pointer
  a_r5_alias_spares_user: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_SP && !flg[FLG_USTK_BIT]) |=> $stable(usp));

  // R6: the flags move only on a flag write
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == SEL_FLG) |=> $stable(flg));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int W    = DW,
  parameter int AW   = PCW,
  parameter int NREG = NBREG
) (
  input  logic [3:0]             sel,
  input  logic [1:0]             wid,
  input  logic [NREG-1:0][W-1:0] bq,
  input  logic [W-1:0]           isp,
  input  logic [W-1:0]           usp,
  input  logic [AW-1:0]          pc,
  input  logic [AW-1:0]          vb,
  input  logic [W-1:0]           sb,
  input  logic [W-1:0]           flg,
  output logic [2*W-1:0]         rdata
);
  localparam int HB = W / 2;

  int idx;
  assign idx = int'(sel[2:0]);

  always_comb begin
    rdata = '0;
    if (rf_legal(sel, wid)) begin
      case (sel)
        SEL_D0, SEL_D1: begin
          case (wid)
            WID_BLO:  rdata[HB-1:0] = bq[idx][HB-1:0];
            WID_BHI:  rdata[HB-1:0] = bq[idx][W-1:HB];
            WID_WORD: rdata[W-1:0]  = bq[idx];
            default:  rdata         = {bq[idx + 2], bq[idx]};
          endcase
        end
        SEL_D2, SEL_D3, SEL_X1, SEL_FRM: rdata[W-1:0] = bq[idx];
        SEL_X0: begin
          if (wid == WID_DWORD) rdata = {bq[SEL_X1], bq[SEL_X0]};
          else                  rdata[W-1:0] = bq[SEL_X0];
        end
        SEL_SP:  rdata[W-1:0] = flg[FLG_USTK_BIT] ? usp : isp;
        SEL_ISP: rdata[W-1:0] = isp;
        SEL_USP: rdata[W-1:0] = usp;
        SEL_PC:  rdata[AW-1:0] = pc;
        SEL_VBH: rdata[AW-W-1:0] = vb[AW-1:W];
        SEL_VBL: begin
          if (wid == WID_DWORD) rdata[AW-1:0] = vb;
          else                  rdata[W-1:0]  = vb[W-1:0];
        end
        SEL_SB:  rdata[W-1:0] = sb;
        SEL_FLG: rdata[W-1:0] = flg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [1:0]  wr_wid,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rda_sel,
  input  logic [1:0]  rda_wid,
  output logic [31:0] rda_data,
  input  logic [3:0]  rdb_sel,
  input  logic [1:0]  rdb_wid,
  output logic [31:0] rdb_data
);
  logic                               rst_q_n;
  logic                               wr_ok;
  logic [NBANK-1:0]                   we_bank;
  logic [NBANK-1:0][NBREG-1:0][DW-1:0] bank_q;
  logic [NBREG-1:0][DW-1:0]           cur_q;
  logic [DW-1:0]                      isp, usp, sb, flg;
  logic [PCW-1:0]                     pc, vb;
  logic                               bank_sel;

  rf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign wr_ok    = wr_en && rf_legal(wr_sel, wr_wid);
  assign bank_sel = flg[FLG_BANK_BIT];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign we_bank[b] = wr_ok && rf_is_banked(wr_sel) && (bank_sel == 1'(b));
    rf_bank #(.W(DW), .NREG(NBREG)) u_bank (
      .clk   (clk),
      .rst_n (rst_q_n),
      .we    (we_bank[b]),
      .sel   (wr_sel),
      .wid   (wr_wid),
      .wdata (wr_data),
      .q     (bank_q[b])
    );
  end

  assign cur_q = bank_q[bank_sel];

  rf_sysregs #(.W(DW), .AW(PCW)) u_sys (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (wr_ok && !rf_is_banked(wr_sel)),
    .sel   (wr_sel),
    .wid   (wr_wid),
    .wdata (wr_data),
    .isp   (isp),
    .usp   (usp),
    .pc    (pc),
    .vb    (vb),
    .sb    (sb),
    .flg   (flg)
  );

  rf_read_port #(.W(DW), .AW(PCW), .NREG(NBREG)) u_rda (
    .sel (rda_sel), .wid (rda_wid), .bq (cur_q),
    .isp (isp), .usp (usp), .pc (pc), .vb (vb), .sb (sb), .flg (flg),
    .rdata (rda_data)
  );

  rf_read_port #(.W(DW), .AW(PCW), .NREG(NBREG)) u_rdb (
    .sel (rdb_sel), .wid (rdb_wid), .bq (cur_q),
    .isp (isp), .usp (usp), .pc (pc), .vb (vb), .sb (sb), .flg (flg),
    .rdata (rdb_data)
  );

  // R2: the idle bank is never written
  a_r2_idle_bank_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bank_sel |=> $stable(bank_q[1]));

  // R10: a rejected write leaves every register alone
  a_r10_reject_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && !rf_legal(wr_sel, wr_wid)) |=>
      ($stable(bank_q) && $stable(flg) && $stable(sb) && $stable(pc) && $stable(vb) &&
       $stable(isp) && $stable(usp)));

  // R10: a rejected read returns zero
  a_r10_reject_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rf_legal(rdb_sel, rdb_wid) |-> (rdb_data == '0));

  // R7: the program counter never shows bits above 19
  a_r7_pc_upper_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rda_sel == SEL_PC) |-> (rda_data[31:PCW] == '0));
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [1:0]  wr_wid;
  logic [31:0] wr_data;
  logic [3:0]  rda_sel, rdb_sel;
  logic [1:0]  rda_wid, rdb_wid;
  logic [31:0] rda_data, rdb_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] m_bank [2][7];
  logic [15:0] m_isp, m_usp, m_sb, m_flg;
  logic [19:0] m_pc, m_vb;

  always #10 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_wid(wr_wid),
    .wr_data(wr_data), .rda_sel(rda_sel), .rda_wid(rda_wid), .rda_data(rda_data),
    .rdb_sel(rdb_sel), .rdb_wid(rdb_wid), .rdb_data(rdb_data)
  );

  function automatic bit ok_code(input logic [3:0] s, input logic [1:0] w);
    if (w < 2)  return s < 2;
    if (w == 2) return s != 10 && s != 15;
    return s == 0 || s == 1 || s == 4 || s == 10 || s == 12;
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic [1:0] w);
    if (!ok_code(s, w)) return "R10";
    if (w < 2)          return "R3";
    if (w == 3 && s < 5) return "R4";
    if (s < 7)          return "R2";
    if (s < 10)         return "R5";
    if (s == 10)        return "R7";
    if (s < 13)         return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] expect_rd(input logic [3:0] s, input logic [1:0] w);
    int b;
    b = m_flg[4];
    if (!ok_code(s, w)) return 32'h0;
    case (s)
      0, 1: begin
        if (w == 0) return {24'h0, m_bank[b][s][7:0]};
        if (w == 1) return {24'h0, m_bank[b][s][15:8]};
        if (w == 2) return {16'h0, m_bank[b][s]};
        return {m_bank[b][s + 2], m_bank[b][s]};
      end
      4: return (w == 3) ? {m_bank[b][5], m_bank[b][4]} : {16'h0, m_bank[b][4]};
      2, 3, 5, 6: return {16'h0, m_bank[b][s]};
      7:  return {16'h0, m_flg[5] ? m_usp : m_isp};
      8:  return {16'h0, m_isp};
      9:  return {16'h0, m_usp};
      10: return {12'h0, m_pc};
      11: return {28'h0, m_vb[19:16]};
      12: return (w == 3) ? {12'h0, m_vb} : {16'h0, m_vb[15:0]};
      13: return {16'h0, m_sb};
      default: return {16'h0, m_flg};
    endcase
  endfunction

  task automatic model_write(input logic [3:0] s, input logic [1:0] w, input logic [31:0] d);
    int b;
    b = m_flg[4];
    if (!ok_code(s, w)) return;
    case (s)
      0, 1: begin
        if (w == 0)      m_bank[b][s][7:0]  = d[7:0];
        else if (w == 1) m_bank[b][s][15:8] = d[7:0];
        else if (w == 2) m_bank[b][s]       = d[15:0];
        else begin m_bank[b][s] = d[15:0]; m_bank[b][s + 2] = d[31:16]; end
      end
      4: begin
        m_bank[b][4] = d[15:0];
        if (w == 3) m_bank[b][5] = d[31:16];
      end
      2, 3, 5, 6: m_bank[b][s] = d[15:0];
      7:  if (m_flg[5]) m_usp = d[15:0]; else m_isp = d[15:0];
      8:  m_isp = d[15:0];
      9:  m_usp = d[15:0];
      10: m_pc = d[19:0];
      11: m_vb[19:16] = d[3:0];
      12: if (w == 3) m_vb = d[19:0]; else m_vb[15:0] = d[15:0];
      13: m_sb = d[15:0];
      default: m_flg = d[15:0];
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check reads before the edge, then apply the write
  task automatic cycle(input logic we, input logic [3:0] s, input logic [1:0] w,
                       input logic [31:0] d);
    @(negedge clk);
    wr_en = we; wr_sel = s; wr_wid = w; wr_data = d;
    #2;
    check(tag_of(rda_sel, rda_wid), rda_data, expect_rd(rda_sel, rda_wid));
    check("R11", rdb_data, expect_rd(rdb_sel, rdb_wid));
    @(posedge clk);
    if (we) model_write(s, w, d);
  endtask

  task automatic peek(input string req, input logic [3:0] s, input logic [1:0] w,
                      input logic [31:0] exp);
    @(negedge clk);
    wr_en = 1'b0; rda_sel = s; rda_wid = w;
    #2;
    check(req, rda_data, exp);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0717));
    for (int b = 0; b < 2; b++) for (int r = 0; r < 7; r++) m_bank[b][r] = '0;
    m_isp = '0; m_usp = '0; m_sb = '0; m_flg = '0; m_pc = '0; m_vb = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_wid = '0; wr_data = '0;
    rda_sel = '0; rda_wid = 2'd2; rdb_sel = '0; rdb_wid = 2'd2;
    repeat (3) @(posedge clk);
    // R1: reads are zero while reset is held
    #2 check("R1", rda_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int s = 0; s < 16; s++) peek("R1", 4'(s), (s == 10) ? 2'd3 : 2'd2, 32'h0);

    // R3: byte halves of data register 0
    cycle(1, 4'd0, 2'd2, 32'h0000_1234);
    cycle(1, 4'd0, 2'd0, 32'h0000_00AB);
    peek("R3", 4'd0, 2'd2, 32'h0000_12AB);
    cycle(1, 4'd0, 2'd1, 32'h0000_00CD);
    peek("R3", 4'd0, 2'd2, 32'h0000_CDAB);
    peek("R3", 4'd0, 2'd1, 32'h0000_00CD);

    // R4: pair write lands both halves
    cycle(1, 4'd1, 2'd3, 32'hDEAD_BEEF);
    peek("R4", 4'd3, 2'd2, 32'h0000_DEAD);
    peek("R4", 4'd1, 2'd2, 32'h0000_BEEF);
    cycle(1, 4'd4, 2'd3, 32'h1111_2222);
    peek("R4", 4'd5, 2'd2, 32'h0000_1111);

    // R6 + R2: flip to bank 1 while reading data 0 in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd14; wr_wid = 2'd2; wr_data = 32'h0000_0010;
    rda_sel = 4'd0; rda_wid = 2'd2;
    #2 check("R6", rda_data, 32'h0000_CDAB);
    @(posedge clk); model_write(4'd14, 2'd2, 32'h0000_0010);
    peek("R6", 4'd0, 2'd2, 32'h0);
    cycle(1, 4'd0, 2'd2, 32'h0000_7777);
    cycle(1, 4'd14, 2'd2, 32'h0);
    peek("R2", 4'd0, 2'd2, 32'h0000_CDAB);

    // R5: stack alias follows flag bit 5
    cycle(1, 4'd7, 2'd2, 32'h0000_0AAA);
    peek("R5", 4'd8, 2'd2, 32'h0000_0AAA);
    cycle(1, 4'd14, 2'd2, 32'h0000_0020);
    cycle(1, 4'd7, 2'd2, 32'h0000_0BBB);
    peek("R5", 4'd9, 2'd2, 32'h0000_0BBB);
    peek("R5", 4'd8, 2'd2, 32'h0000_0AAA);

    // R7 / R8: 20-bit registers
    cycle(1, 4'd10, 2'd3, 32'hFFFF_FFFF);
    peek("R7", 4'd10, 2'd3, 32'h000F_FFFF);
    peek("R7", 4'd10, 2'd2, 32'h0);
    cycle(1, 4'd11, 2'd2, 32'h0000_FFF9);
    cycle(1, 4'd12, 2'd2, 32'h0000_4321);
    peek("R8", 4'd12, 2'd3, 32'h0009_4321);
    peek("R8", 4'd11, 2'd2, 32'h0000_0009);

    // R10 / R9: rejected byte write to static base
    cycle(1, 4'd13, 2'd2, 32'h0000_5A5A);
    cycle(1, 4'd13, 2'd0, 32'h0000_00FF);
    peek("R9", 4'd13, 2'd2, 32'h0000_5A5A);
    peek("R10", 4'd15, 2'd2, 32'h0);

    // random traffic on both ports
    for (int i = 0; i < 5000; i++) begin
      logic [3:0] s;
      logic [1:0] w;
      s = 4'($urandom_range(0, 15));
      w = 2'($urandom_range(0, 3));
      if (($urandom_range(0, 3) == 0)) begin s = 4'($urandom_range(0, 1)); w = 2'($urandom_range(0, 1)); end
      if (($urandom_range(0, 7) == 0)) begin s = 4'd14; w = 2'd2; end
      rda_sel = 4'($urandom_range(0, 15)); rda_wid = 2'($urandom_range(0, 3));
      rdb_sel = 4'($urandom_range(0, 15)); rdb_wid = 2'($urandom_range(0, 3));
      cycle(($urandom_range(0, 9) < 7), s, w, $urandom);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule